// File: doc/BRIEF.md
# Seeded Bit-Serial CRC Engine

This block folds a stream of bytes into a cyclic redundancy remainder. It uses a shift register with XOR feedback, so every add and subtract step of the polynomial long division is an XOR. The width and the divisor polynomial are parameters. The polynomial is written in the notation where the most significant set bit is the highest-degree term and the x^0 term is implied. The block turns that value into its own feedback taps. The same RTL therefore covers 8-bit divisors such as 0xA6, 0x97 or 0xEA and 32-bit divisors such as 0xBA0DC66B.

A message begins with a clear strobe, which loads the register from a seed input. With a nonzero seed, a run of zero bytes still yields a nonzero check value. Each accepted byte is then shifted in one bit per clock, most significant bit first, and a busy flag is raised while the bits are being consumed. The transmitter appends the register value after the data. At the far end, the end-of-message strobe compares the running remainder against the check value that was received and reports whether the two agree.

Top module: `crc_serial_engine`

## Requirements
- R1: After reset, crc_o, busy_o, done_o and match_o are all zero.
- R2: A cycle with start_i high loads seed_i into the remainder, which crc_o shows after that edge. The same edge clears busy_o, done_o and match_o and drops any byte still being shifted.
- R3: A byte is taken when valid_i is high, busy_o is low and start_i is low. busy_o is then high in exactly the 8 cycles that follow that edge and low again after them.
- R4: valid_i is ignored while busy_o is high or while start_i is high. Such a cycle does not change the remainder or the bits still queued.
- R5: Each bit b, taken MSB first, updates the remainder c of width CRC_W as fb = c[CRC_W-1] ^ b, c = (c << 1) ^ (fb ? T : 0). The tap vector T is ((POLY << 1) | 1) truncated to CRC_W bits, where bit k of POLY is the coefficient of x^(k+1).
- R6: After the last byte's 8 shifts, crc_o equals the remainder of (M(x)·x^CRC_W + S(x)·x^L) divided by the full polynomial. Here M is the message bit string, L is its length in bits and S is the seed.
- R7: An end-of-message cycle (eom_i high, busy_o low, start_i low) raises done_o for the next cycle. From that cycle, match_o shows whether crc_o equalled rx_crc_i at the strobe, and it holds until the next start or end-of-message. eom_i while busy_o is high produces no done_o.
- R8: With CRC_W = 32 and POLY = 0xBA0DC66B, R2 to R7 hold unchanged, with no change to the RTL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start of message: load seed, abort shifting |
| seed_i | input | CRC_W | Initial remainder |
| valid_i | input | 1 | Data byte present |
| data_i | input | 8 | Data byte, MSB shifted first |
| eom_i | input | 1 | End of message: compare strobe |
| rx_crc_i | input | CRC_W | Received check value |
| busy_o | output | 1 | Byte bits still being shifted |
| crc_o | output | CRC_W | Running remainder |
| done_o | output | 1 | One-cycle pulse after a compare |
| match_o | output | 1 | Last compare found equality |

## Verification
The embedded properties check every cycle that a taken byte raises busy, that a start loads the seed and clears the match flag, that an idle register stays put, and that a compare strobe yields a done pulse. The remainder value itself can only be shown by the bench's scenarios. The bench compares it for both the 8-bit and the 32-bit configuration against an independent long-division model, over fixed and random messages and seeds. The bench scenarios also show the exact 8-cycle busy window, the bytes dropped while busy or during a start, and an abort in mid-byte. They cover agreeing and disagreeing received values as well.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [CNT_W-1:0]  cnt_t;
endpackage

// File: rtl/crc_bit_sequencer.sv
module crc_bit_sequencer
  import crc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clear_i,
  input  logic  valid_i,
  input  byte_t data_i,
  output logic  busy_o,
  output logic  shift_o,
  output logic  bit_o
);
  byte_t shreg_q;
  cnt_t  cnt_q;
  logic  accept;

  assign busy_o  = (cnt_q != '0);
  assign accept  = valid_i && !busy_o && !clear_i;
  assign shift_o = busy_o && !clear_i;
  assign bit_o   = shreg_q[BYTE_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (clear_i) begin
      cnt_q   <= '0;
    end else if (accept) begin
      shreg_q <= data_i;
      cnt_q   <= cnt_t'(BYTE_W);
    end else if (busy_o) begin
      shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
      cnt_q   <= cnt_q - cnt_t'(1);
    end
  end

  // R3
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !busy_o && !clear_i) |=> busy_o);

  // R4
  busy_no_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !clear_i) |=> (shreg_q == {$past(shreg_q[BYTE_W-2:0]), 1'b0}));
endmodule

// File: rtl/crc_lfsr_reg.sv
module crc_lfsr_reg #(
  parameter int unsigned      CRC_W = 8,
  parameter logic [CRC_W-1:0] TAPS  = 8'h4D
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [CRC_W-1:0] seed_i,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q, crc_d;
  logic             fb;

  assign fb = crc_q[CRC_W-1] ^ bit_i;

  assign crc_d[0] = fb & TAPS[0];
  for (genvar i = 1; i < CRC_W; i++) begin : g_stage
    assign crc_d[i] = crc_q[i-1] ^ (fb & TAPS[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '0;
    else if (clear_i) crc_q <= seed_i;
    else if (shift_i) crc_q <= crc_d;
  end

  assign crc_o = crc_q;

  // R2
  seed_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (crc_o == $past(seed_i)));

  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !shift_i) |=> $stable(crc_o));
endmodule

// File: rtl/crc_match_unit.sv
module crc_match_unit #(
  parameter int unsigned CRC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             eom_i,
  input  logic             busy_i,
  input  logic [CRC_W-1:0] crc_i,
  input  logic [CRC_W-1:0] rx_crc_i,
  output logic             done_o,
  output logic             match_o
);
  logic fire;
  assign fire = eom_i && !busy_i && !clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      match_o <= 1'b0;
    end else if (clear_i) begin
      done_o  <= 1'b0;
      match_o <= 1'b0;
    end else begin
      done_o <= fire;
      if (fire) match_o <= (crc_i == rx_crc_i);
    end
  end

  // R7
  eom_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> done_o);

  // R7
  busy_no_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !clear_i) |=> !done_o);

  // R2
  clear_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!match_o && !done_o));
endmodule

// File: rtl/crc_serial_engine.sv
module crc_serial_engine
  import crc_pkg::*;
#(
  parameter int unsigned      CRC_W = 8,
  parameter logic [CRC_W-1:0] POLY  = 8'hA6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CRC_W-1:0] seed_i,
  input  logic             valid_i,
  input  logic [7:0]       data_i,
  input  logic             eom_i,
  input  logic [CRC_W-1:0] rx_crc_i,
  output logic             busy_o,
  output logic [CRC_W-1:0] crc_o,
  output logic             done_o,
  output logic             match_o
);
  // implied x^0 term becomes tap 0, explicit top term drops out
  localparam logic [CRC_W-1:0] TAPS = {POLY[CRC_W-2:0], 1'b1};

  logic shift, bit_in;

  crc_bit_sequencer i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (start_i),
    .valid_i (valid_i),
    .data_i  (data_i),
    .busy_o  (busy_o),
    .shift_o (shift),
    .bit_o   (bit_in)
  );

  crc_lfsr_reg #(.CRC_W(CRC_W), .TAPS(TAPS)) i_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (start_i),
    .seed_i  (seed_i),
    .shift_i (shift),
    .bit_i   (bit_in),
    .crc_o   (crc_o)
  );

  crc_match_unit #(.CRC_W(CRC_W)) i_match (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (start_i),
    .eom_i    (eom_i),
    .busy_i   (busy_o),
    .crc_i    (crc_o),
    .rx_crc_i (rx_crc_i),
    .done_o   (done_o),
    .match_o  (match_o)
  );
endmodule

// File: tb/test_crc_serial_engine.sv
`timescale 1ns/1ps
module test_crc_serial_engine;
  localparam logic [7:0]  P8  = 8'hA6;
  localparam logic [31:0] P32 = 32'hBA0DC66B;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start = 1'b0, valid = 1'b0, eom = 1'b0;
  logic [7:0]  data = '0, seed8 = '0, rx8 = '0;
  logic [31:0] seed32 = '0, rx32 = '0;
  logic busy8, done8, match8, busy32, done32, match32;
  logic [7:0]  crc8;
  logic [31:0] crc32;

  int checks = 0, errors = 0;
  logic [7:0] msg [0:15];

  always #4 clk = ~clk;

  crc_serial_engine #(.CRC_W(8), .POLY(P8)) i_crc_serial_engine (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .seed_i(seed8),
    .valid_i(valid), .data_i(data), .eom_i(eom), .rx_crc_i(rx8),
    .busy_o(busy8), .crc_o(crc8), .done_o(done8), .match_o(match8));

  crc_serial_engine #(.CRC_W(32), .POLY(P32)) i_crc_serial_engine_w32 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .seed_i(seed32),
    .valid_i(valid), .data_i(data), .eom_i(eom), .rx_crc_i(rx32),
    .busy_o(busy32), .crc_o(crc32), .done_o(done32), .match_o(match32));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  // long-division model: remainder of (M*x^W + S*x^L) mod P
  function automatic logic [31:0] ref_crc(input int w, input logic [31:0] poly,
                                          input logic [31:0] seed, input int n);
    logic a [0:191];
    logic [31:0] g, r;
    int len;
    len = n * 8;
    g = (poly << 1) | 32'd1;
    for (int i = 0; i < 192; i++) a[i] = 1'b0;
    for (int b = 0; b < n; b++)
      for (int k = 0; k < 8; k++) a[b*8+k] = msg[b][7-k];
    for (int j = 0; j < w; j++) a[j] = a[j] ^ seed[w-1-j];
    for (int i = 0; i < len; i++)
      if (a[i]) begin
        a[i] = 1'b0;
        for (int j = 0; j < w; j++) a[i+1+j] = a[i+1+j] ^ g[w-1-j];
      end
    r = '0;
    for (int j = 0; j < w; j++) r[w-1-j] = a[len+j];
    return r;
  endfunction

  task automatic do_start(input logic [7:0] s8, input logic [31:0] s32);
    seed8 = s8; seed32 = s32; start = 1'b1;
    step();
    start = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    int guard;
    data = b; valid = 1'b1;
    step();
    valid = 1'b0;
    guard = 0;
    while (busy8 && guard < 20) begin step(); guard++; end
  endtask

  task automatic send_msg(input int n);
    for (int i = 0; i < n; i++) send_byte(msg[i]);
  endtask

  task automatic check_msg(input string req, input int n, input logic [7:0] s8,
                           input logic [31:0] s32);
    do_start(s8, s32);
    send_msg(n);
    chk({req, " crc8"},  {24'd0, crc8}, ref_crc(8, {24'd0, P8}, {24'd0, s8}, n));
    chk({req, " crc32"}, crc32,         ref_crc(32, P32, s32, n));
  endtask

  task automatic t_reset();
    chk("R1 crc8",  {24'd0, crc8}, 32'd0);
    chk("R1 crc32", crc32, 32'd0);
    chk("R1 flags", {28'd0, busy8, done8, match8, busy32}, 32'd0);
  endtask

  task automatic t_start();
    do_start(8'h5A, 32'hDEADBEEF);
    chk("R2 seed8",  {24'd0, crc8}, 32'h5A);
    chk("R2 seed32", crc32, 32'hDEADBEEF);
  endtask

  task automatic t_busy();
    int n;
    do_start(8'h00, 32'h0);
    data = 8'hC3; valid = 1'b1;
    step();
    valid = 1'b0;
    n = 0;
    while (busy8 && n < 20) begin n++; step(); end
    chk("R3 busy cycles", n, 8);
    chk("R3 busy32 low", {31'd0, busy32}, 32'd0);
  endtask

  task automatic t_known();
    msg[0] = 8'h00; msg[1] = 8'h00; msg[2] = 8'h00; msg[3] = 8'h00;
    check_msg("R6 zeros seeded", 4, 8'hFF, 32'hFFFFFFFF);
    chk("R6 zeros seeded nonzero", {31'd0, (crc8 != 8'h00)}, 32'd1);
    msg[0] = 8'h80;
    check_msg("R5 single bit", 1, 8'h00, 32'h0);
    chk("R5 tap vector", {24'd0, crc8}, ref_crc(8, {24'd0, P8}, 32'd0, 1));
    msg[0] = 8'h31; msg[1] = 8'h32; msg[2] = 8'h33;
    check_msg("R6 ascii", 3, 8'h1D, 32'h12345678);
  endtask

  task automatic t_random();
    for (int t = 0; t < 8; t++) begin
      int n;
      n = 1 + ($urandom % 14);
      for (int i = 0; i < n; i++) msg[i] = 8'($urandom);
      check_msg("R8 random", n, 8'($urandom), $urandom);
    end
  endtask

  task automatic t_ignore();
    int guard;
    msg[0] = 8'hA5; msg[1] = 8'h3C;
    do_start(8'h77, 32'hCAFEF00D);
    data = msg[0]; valid = 1'b1;
    step();
    data = 8'hFF;
    step(); step();
    valid = 1'b0;
    guard = 0;
    while (busy8 && guard < 20) begin step(); guard++; end
    send_byte(msg[1]);
    chk("R4 valid during busy crc8", {24'd0, crc8}, ref_crc(8, {24'd0, P8}, 32'h77, 2));
    chk("R4 valid during busy crc32", crc32, ref_crc(32, P32, 32'hCAFEF00D, 2));
    seed8 = 8'h42; seed32 = 32'h0BADCAFE; start = 1'b1; valid = 1'b1; data = 8'h99;
    step();
    start = 1'b0; valid = 1'b0;
    chk("R4 valid with start busy", {31'd0, busy8}, 32'd0);
    chk("R4 valid with start crc", {24'd0, crc8}, 32'h42);
  endtask

  task automatic t_abort();
    do_start(8'h10, 32'h10);
    data = 8'hF0; valid = 1'b1;
    step();
    valid = 1'b0;
    step(); step();
    seed8 = 8'h3E; seed32 = 32'h3E3E3E3E; start = 1'b1;
    step();
    start = 1'b0;
    chk("R2 abort busy", {31'd0, busy8}, 32'd0);
    chk("R2 abort crc8", {24'd0, crc8}, 32'h3E);
    step();
    chk("R2 abort crc stays", crc32, 32'h3E3E3E3E);
  endtask

  task automatic t_eom();
    logic [7:0]  e8;
    logic [31:0] e32;
    msg[0] = 8'h12; msg[1] = 8'hEF; msg[2] = 8'h07;
    check_msg("R7 setup", 3, 8'hC1, 32'h89ABCDEF);
    e8 = crc8; e32 = crc32;
    rx8 = e8; rx32 = e32 ^ 32'h0001_0000; eom = 1'b1;
    step();
    eom = 1'b0;
    chk("R7 done", {30'd0, done8, done32}, 32'd3);
    chk("R7 match8 good", {31'd0, match8}, 32'd1);
    chk("R7 match32 bad", {31'd0, match32}, 32'd0);
    step();
    chk("R7 done pulse", {30'd0, done8, done32}, 32'd0);
    chk("R7 match holds", {31'd0, match8}, 32'd1);
    rx8 = e8 ^ 8'h01; rx32 = e32; eom = 1'b1;
    step();
    eom = 1'b0;
    chk("R7 match8 bad", {31'd0, match8}, 32'd0);
    chk("R7 match32 good", {31'd0, match32}, 32'd1);
    data = 8'h55; valid = 1'b1;
    step();
    valid = 1'b0; eom = 1'b1;
    step();
    eom = 1'b0;
    chk("R7 eom while busy", {30'd0, done8, done32}, 32'd0);
    do_start(8'h01, 32'h1);
    chk("R2 start clears match", {30'd0, match8, match32}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(); step();
    t_reset();
    rst_ni = 1'b1;
    step();
    t_start();
    t_busy();
    t_known();
    t_random();
    t_ignore();
    t_abort();
    t_eom();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule